// File: doc/BRIEF.md
# SDRAM Bank and Power-State Monitor

This block sits beside an SDRAM command bus and only listens. Every clock it decodes the command from the chip-select, row-strobe, column-strobe and write-enable lines. It keeps an open or idle flag for each bank and times the recovery period that follows a precharge. It also follows the clock-enable line into and out of power-down, and reports whether the memory went to sleep with every bank idle or with a row still open. It drives no signal back onto the bus.

Protocol breaches raise a sticky error flag. A two-bit cause code records the first breach seen since reset. The monitor also follows each write burst beat by beat. One cycle after each data beat that really lands in memory, it pulses a beat-valid output. A beat does not count when the mask line is high in its cycle, or when it shares its cycle with the command that cuts the burst short.

Commands are decoded as follows, with CS#, RAS#, CAS# and WE# written in that order (L = low, H = high):

| Command | Lines |
|---|---|
| inhibit | CS# high |
| NOP | L-H-H-H |
| ACTIVE | L-L-H-H |
| READ | L-H-L-H |
| WRITE | L-H-L-L |
| burst stop | L-H-H-L |
| PRECHARGE | L-L-H-L |

A command only takes effect when clock enable is high and the device is not powered down.

Top module: `sdram_bank_pwr_mon`

## Requirements
- R1: A PRECHARGE with `a10` high closes every bank on the next cycle, whatever the value of `ba`. The command encodings are those in the table above.
- R2: A PRECHARGE with `a10` low closes only the bank numbered by `ba`. The open flags of all other banks stay as they were.
- R3: A READ or WRITE to a bank whose flag shows idle sets `err`, with `err_code` = 1.
- R4: Each bank may be activated again only `T_RP` cycles or more after its own precharge. An ACTIVE at an earlier cycle sets `err` with `err_code` = 2. Issuing the ACTIVE exactly `T_RP` cycles after the precharge is legal.
- R5: Power-down is entered when `cke` is low together with a NOP or inhibit, while no write burst is running. `pd_active` is high on the following cycle. `cke` low with any other command, or during a write burst, does not enter power-down.
- R6: `pd_kind` is 0 when every bank was idle at entry and 1 when any bank was open. It holds its value for the whole power-down.
- R7: Power-down is left when `cke` is high together with a NOP or inhibit. Commands sampled during power-down have no effect on the bank flags.
- R8: When power-down lasts more than `PD_MAX` cycles after the entry cycle, `err` is set with `err_code` = 3. Exactly `PD_MAX` cycles followed by an exit raises no error.
- R9: A WRITE starts a burst of `BURST_LEN` beats, with the WRITE cycle as beat 0. One cycle after each beat sampled with `dqm` low, `wbeat_valid` is high. Beats with `dqm` high do not pulse the output.
- R10: A burst stop command during a write burst drops the beat of its own cycle, even with `dqm` low, and no later beat is reported.
- R11: A PRECHARGE during a write burst ends the burst the same way: the beat of its cycle is dropped. It also closes its bank.
- R12: With `BURST_LEN` = 0 (full page) a write burst runs on until a burst stop or PRECHARGE ends it.
- R13: `err` stays high once set, and `err_code` keeps the first cause until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10 (all-bank select on precharge) |
| dqm | input | 1 | Write data mask |
| bank_open | output | NUM_BANKS | One open-row flag per bank |
| pd_active | output | 1 | Device is in power-down |
| pd_kind | output | 1 | 0 precharge power-down, 1 active power-down |
| err | output | 1 | Sticky protocol error |
| err_code | output | 2 | First error cause (1 access to idle bank, 2 early activate, 3 power-down too long) |
| wbeat_valid | output | 1 | A write beat reached memory in the previous cycle |

## Verification
The bench sweeps every mask pattern of a four-beat write against every cut-off point and both kinds of terminator. A design that stored the beat sampled with the terminator, or that kept counting after it, would report one extra beat. The recovery window is swept by one cycle on each side of `T_RP`, so a counter that is off by one either flags a legal ACTIVE or misses an early one. The power-down dwell is tried at `PD_MAX` - 1, `PD_MAX` and `PD_MAX` + 1 cycles, which exposes a dwell counter that is off by one. Precharge is tried on each bank number with `a10` high and low, which catches an all-bank decode that still looks at `ba`, or a single-bank precharge that closes its neighbours.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_INHIBIT,
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_BST,
        CMD_PRE,
        CMD_OTHER
    } cmd_e;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_RW_IDLE   = 2'd1,
        ERR_ACT_EARLY = 2'd2,
        ERR_PD_LONG   = 2'd3
    } err_e;

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = CMD_INHIBIT;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  c = CMD_NOP;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b110:  c = CMD_BST;
                3'b010:  c = CMD_PRE;
                default: c = CMD_OTHER;
            endcase
        end
        return c;
    endfunction

    function automatic logic is_quiet(input cmd_e c);
        return (c == CMD_NOP) || (c == CMD_INHIBIT);
    endfunction

endpackage

// File: rtl/sdram_bank_state.sv
module sdram_bank_state
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RP      = 3,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int RP_W     = (T_RP > 1) ? $clog2(T_RP) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  cmd_e                 op,
    input  logic [BA_W-1:0]      ba,
    input  logic                 a10,
    output logic [NUM_BANKS-1:0] open_o,
    output logic                 rw_idle_o,
    output logic                 act_early_o
);

    localparam logic [RP_W-1:0] RP_INIT = RP_W'(T_RP - 1);

    logic [NUM_BANKS-1:0] idle_hit;
    logic [NUM_BANKS-1:0] early_hit;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic            open_r;
        logic [RP_W-1:0] rp_r;
        logic            sel;
        logic            pre_hit;
        logic            act_hit;

        assign sel     = (ba == BA_W'(i));
        assign pre_hit = go && (op == CMD_PRE) && (a10 || sel);
        assign act_hit = go && (op == CMD_ACT) && sel;

        always_ff @(posedge clk) begin
            if (rst) begin
                open_r <= 1'b0;
                rp_r   <= '0;
            end else begin
                if (pre_hit) begin
                    open_r <= 1'b0;
                    rp_r   <= RP_INIT;
                end else begin
                    if (act_hit) open_r <= 1'b1;
                    if (rp_r != '0) rp_r <= rp_r - 1'b1;
                end
            end
        end

        assign open_o[i]    = open_r;
        assign early_hit[i] = act_hit && (rp_r != '0);
        assign idle_hit[i]  = go && ((op == CMD_RD) || (op == CMD_WR)) && sel && !open_r;

        AST_PRE_ONE_SPARES_OTHERS: assert property (@(posedge clk) disable iff (rst)
            (go && (op == CMD_PRE) && !a10 && !sel) |=> $stable(open_r)); // R2
    end

    assign rw_idle_o   = |idle_hit;
    assign act_early_o = |early_hit;

    AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (go && (op == CMD_PRE) && a10) |=> (open_o == '0)); // R1

endmodule

// File: rtl/sdram_pd_track.sv
module sdram_pd_track
    import sdram_mon_pkg::*;
#(
    parameter int PD_MAX = 12_800_000,
    localparam int PC_W  = $clog2(PD_MAX + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  cmd_e op,
    input  logic any_open,
    input  logic burst_busy,
    output logic pd_o,
    output logic pd_kind_o,
    output logic pd_long_o
);

    localparam logic [PC_W-1:0] CNT_CAP = PC_W'(PD_MAX);

    logic            pd_r;
    logic            kind_r;
    logic [PC_W-1:0] dwell_r;
    logic            enter;
    logic            leave;

    assign enter = !pd_r && !cke && is_quiet(op) && !burst_busy;
    assign leave = pd_r && cke && is_quiet(op);

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_r    <= 1'b0;
            kind_r  <= 1'b0;
            dwell_r <= '0;
        end else if (enter) begin
            pd_r    <= 1'b1;
            kind_r  <= any_open;
            dwell_r <= '0;
        end else if (leave) begin
            pd_r    <= 1'b0;
        end else if (pd_r && dwell_r != CNT_CAP) begin
            dwell_r <= dwell_r + 1'b1;
        end
    end

    assign pd_o      = pd_r;
    assign pd_kind_o = kind_r;
    assign pd_long_o = pd_r && !leave && (dwell_r == CNT_CAP);

    AST_PD_KIND_HELD: assert property (@(posedge clk) disable iff (rst)
        (pd_r && $past(pd_r)) |-> $stable(kind_r)); // R6

    AST_PD_ENTRY_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_r) |-> ($past(!cke) && $past(!burst_busy))); // R5

endmodule

// File: rtl/sdram_wr_beat.sv
module sdram_wr_beat
    import sdram_mon_pkg::*;
#(
    parameter int BURST_LEN = 8,
    localparam int BC_W     = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  cmd_e op,
    input  logic dqm,
    output logic busy_o,
    output logic beat_ok_o
);

    localparam logic [BC_W-1:0] REM_INIT = (BURST_LEN > 1) ? BC_W'(BURST_LEN - 1) : '0;
    localparam logic            FULL_PAGE = (BURST_LEN == 0);

    logic            busy_r;
    logic [BC_W-1:0] rem_r;
    logic            ok_r;
    logic            carry_on;
    logic            beat_now;

    assign carry_on = busy_r && (is_quiet(op) || op == CMD_ACT);
    assign beat_now = go && ((op == CMD_WR) || carry_on);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_r <= 1'b0;
            rem_r  <= '0;
            ok_r   <= 1'b0;
        end else begin
            ok_r <= beat_now && !dqm;
            if (go) begin
                if (op == CMD_WR) begin
                    busy_r <= (BURST_LEN != 1);
                    rem_r  <= REM_INIT;
                end else if (op == CMD_BST || op == CMD_PRE || op == CMD_RD) begin
                    busy_r <= 1'b0;
                end else if (carry_on && !FULL_PAGE) begin
                    rem_r <= rem_r - 1'b1;
                    if (rem_r == BC_W'(1)) busy_r <= 1'b0;
                end
            end
        end
    end

    assign busy_o    = busy_r;
    assign beat_ok_o = ok_r;

    AST_BEAT_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        ok_r |-> $past(!dqm)); // R9

    AST_STOP_DROPS_BEAT: assert property (@(posedge clk) disable iff (rst)
        (go && (op == CMD_BST || op == CMD_PRE)) |=> !ok_r); // R10

endmodule

// File: rtl/sdram_bank_pwr_mon.sv
module sdram_bank_pwr_mon
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RP      = 3,
    parameter int PD_MAX    = 12_800_000,
    parameter int BURST_LEN = 8,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 cke,
    input  logic [BA_W-1:0]      ba,
    input  logic                 a10,
    input  logic                 dqm,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 pd_active,
    output logic                 pd_kind,
    output logic                 err,
    output logic [1:0]           err_code,
    output logic                 wbeat_valid
);

    cmd_e op;
    logic go;
    logic rw_idle;
    logic act_early;
    logic pd_long;
    logic burst_busy;
    err_e cause;
    logic err_r;
    err_e code_r;

    assign op = decode_cmd(cs_n, ras_n, cas_n, we_n);
    assign go = cke && !pd_active;

    sdram_bank_state #(.NUM_BANKS(NUM_BANKS), .T_RP(T_RP)) u_banks (
        .clk(clk), .rst(rst), .go(go), .op(op), .ba(ba), .a10(a10),
        .open_o(bank_open), .rw_idle_o(rw_idle), .act_early_o(act_early)
    );

    sdram_pd_track #(.PD_MAX(PD_MAX)) u_pd (
        .clk(clk), .rst(rst), .cke(cke), .op(op), .any_open(|bank_open),
        .burst_busy(burst_busy), .pd_o(pd_active), .pd_kind_o(pd_kind),
        .pd_long_o(pd_long)
    );

    sdram_wr_beat #(.BURST_LEN(BURST_LEN)) u_wr (
        .clk(clk), .rst(rst), .go(go), .op(op), .dqm(dqm),
        .busy_o(burst_busy), .beat_ok_o(wbeat_valid)
    );

    always_comb begin
        cause = ERR_NONE;
        if (rw_idle)        cause = ERR_RW_IDLE;
        else if (act_early) cause = ERR_ACT_EARLY;
        else if (pd_long)   cause = ERR_PD_LONG;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_r  <= 1'b0;
            code_r <= ERR_NONE;
        end else if (!err_r && cause != ERR_NONE) begin
            err_r  <= 1'b1;
            code_r <= cause;
        end
    end

    assign err      = err_r;
    assign err_code = code_r;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> (err && $stable(err_code))); // R13

    AST_PD_FREEZES_BANKS: assert property (@(posedge clk) disable iff (rst)
        pd_active |=> $stable(bank_open)); // R7

endmodule

// File: tb/tb_sdram_bank_pwr_mon.sv
`timescale 1ns/1ps
module tb_sdram_bank_pwr_mon;

    localparam logic [3:0] C_INH = 4'b1111;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_BST = 4'b0110;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam int TRP  = 2;
    localparam int PDM  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic cke = 1'b1, a10 = 1'b0, dqm = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [3:0] bank_open, fp_open;
    logic pd_active, pd_kind, err, wbeat_valid;
    logic fp_pd, fp_kind, fp_err, fp_wbeat;
    logic [1:0] err_code, fp_code;
    int vectors = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sdram_bank_pwr_mon #(.NUM_BANKS(4), .T_RP(TRP), .PD_MAX(PDM), .BURST_LEN(4)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ba(ba), .a10(a10), .dqm(dqm), .bank_open(bank_open),
        .pd_active(pd_active), .pd_kind(pd_kind), .err(err), .err_code(err_code),
        .wbeat_valid(wbeat_valid)
    );

    sdram_bank_pwr_mon #(.NUM_BANKS(4), .T_RP(TRP), .PD_MAX(PDM), .BURST_LEN(0)) dut_fp (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ba(ba), .a10(a10), .dqm(dqm), .bank_open(fp_open),
        .pd_active(fp_pd), .pd_kind(fp_kind), .err(fp_err), .err_code(fp_code),
        .wbeat_valid(fp_wbeat)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic issue(input logic [3:0] c, input int b, input logic a, input logic dm,
                         input logic ck);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba = b[1:0];
        a10 = a;
        dqm = dm;
        cke = ck;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        issue(C_NOP, 0, 1'b0, 1'b0, 1'b1);
        issue(C_NOP, 0, 1'b0, 1'b0, 1'b1);
        rst = 1'b0;
    endtask

    task automatic open_all();
        for (int b = 0; b < 4; b++) issue(C_ACT, b, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: got 0 expected 1 (run finished)");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R13 reset err", int'(err), 0);
        check("R13 reset code", int'(err_code), 0);
        check("R5 reset pd", int'(pd_active), 0);
        check("R1 reset banks", int'(bank_open), 0);
        check("R9 reset beat", int'(wbeat_valid), 0);

        // R1 and R2: precharge on each bank number, all-bank and single
        for (int t = 0; t < 4; t++) begin
            do_reset();
            open_all();
            check("R1 banks opened", int'(bank_open), 15);
            issue(C_PRE, t, 1'b0, 1'b0, 1'b1);
            check("R2 single precharge", int'(bank_open), 15 & ~(1 << t));
            do_reset();
            open_all();
            issue(C_PRE, t, 1'b1, 1'b0, 1'b1);
            check("R1 all-bank precharge", int'(bank_open), 0);
            check("R1 no error", int'(err), 0);
        end

        // R4: recovery window sweep
        for (int d = 0; d < 4; d++) begin
            do_reset();
            issue(C_ACT, 1, 1'b0, 1'b0, 1'b1);
            issue(C_PRE, 1, 1'b0, 1'b0, 1'b1);
            for (int n = 0; n < d; n++) issue(C_NOP, 0, 1'b0, 1'b0, 1'b1);
            issue(C_ACT, 1, 1'b0, 1'b0, 1'b1);
            check("R4 early activate err", int'(err), (d + 1 < TRP) ? 1 : 0);
            check("R4 early activate code", int'(err_code), (d + 1 < TRP) ? 2 : 0);
            check("R4 bank reopened", int'(bank_open[1]), 1);
        end
        do_reset();
        issue(C_ACT, 1, 1'b0, 1'b0, 1'b1);
        issue(C_PRE, 1, 1'b0, 1'b0, 1'b1);
        issue(C_ACT, 2, 1'b0, 1'b0, 1'b1);
        check("R4 other bank unaffected", int'(err), 0);

        // R3 and R13
        do_reset();
        issue(C_RD, 0, 1'b0, 1'b0, 1'b1);
        check("R3 read idle err", int'(err), 1);
        check("R3 read idle code", int'(err_code), 1);
        do_reset();
        issue(C_ACT, 2, 1'b0, 1'b0, 1'b1);
        issue(C_WR, 2, 1'b0, 1'b0, 1'b1);
        check("R3 write open bank ok", int'(err), 0);
        issue(C_PRE, 2, 1'b0, 1'b0, 1'b1);
        issue(C_NOP, 0, 1'b0, 1'b0, 1'b1);
        issue(C_NOP, 0, 1'b0, 1'b0, 1'b1);
        issue(C_WR, 2, 1'b0, 1'b0, 1'b1);
        check("R3 write after precharge code", int'(err_code), 1);
        do_reset();
        issue(C_ACT, 3, 1'b0, 1'b0, 1'b1);
        issue(C_PRE, 3, 1'b0, 1'b0, 1'b1);
        issue(C_ACT, 3, 1'b0, 1'b0, 1'b1);
        issue(C_RD, 0, 1'b0, 1'b0, 1'b1);
        issue(C_NOP, 0, 1'b0, 1'b0, 1'b1);
        check("R13 first cause kept", int'(err_code), 2);
        check("R13 still set", int'(err), 1);
        do_reset();
        check("R13 cleared by reset", int'(err), 0);

        // R5, R6, R7: power-down kinds, freeze, exit
        do_reset();
        issue(C_NOP, 0, 1'b0, 1'b0, 1'b0);
        check("R5 enter pd", int'(pd_active), 1);
        check("R6 precharge pd", int'(pd_kind), 0);
        issue(C_INH, 0, 1'b0, 1'b0, 1'b1);
        check("R7 exit pd", int'(pd_active), 0);
        do_reset();
        issue(C_ACT, 3, 1'b0, 1'b0, 1'b1);
        issue(C_ACT, 0, 1'b0, 1'b0, 1'b0);
        check("R5 non-quiet no entry", int'(pd_active), 0);
        issue(C_INH, 0, 1'b0, 1'b0, 1'b0);
        check("R5 enter via inhibit", int'(pd_active), 1);
        check("R6 active pd", int'(pd_kind), 1);
        issue(C_PRE, 0, 1'b1, 1'b0, 1'b0);
        issue(C_PRE, 0, 1'b1, 1'b0, 1'b1);
        check("R7 stays in pd on non-quiet", int'(pd_active), 1);
        check("R6 kind held", int'(pd_kind), 1);
        issue(C_NOP, 0, 1'b0, 1'b0, 1'b1);
        check("R7 exit", int'(pd_active), 0);
        check("R7 banks untouched", int'(bank_open), 8);
        do_reset();
        issue(C_ACT, 0, 1'b0, 1'b0, 1'b1);
        issue(C_WR, 0, 1'b0, 1'b0, 1'b1);
        issue(C_NOP, 0, 1'b0, 1'b0, 1'b0);
        check("R5 no entry mid burst", int'(pd_active), 0);

        // R8: dwell sweep around the limit
        for (int n = PDM - 1; n <= PDM + 1; n++) begin
            do_reset();
            issue(C_NOP, 0, 1'b0, 1'b0, 1'b0);
            for (int s = 0; s < n; s++) issue(C_NOP, 0, 1'b0, 1'b0, 1'b0);
            issue(C_NOP, 0, 1'b0, 1'b0, 1'b1);
            check("R8 dwell err", int'(err), (n > PDM) ? 1 : 0);
            check("R8 dwell code", int'(err_code), (n > PDM) ? 3 : 0);
            check("R8 exited", int'(pd_active), 0);
        end

        // R9, R10, R11: every mask pattern, cut point and terminator
        for (int p = 1; p <= 4; p++) begin
            for (int m = 0; m < 16; m++) begin
                for (int k = 0; k < 2; k++) begin
                    do_reset();
                    issue(C_ACT, 0, 1'b0, 1'b0, 1'b1);
                    for (int i = 0; i < 4; i++) begin
                        int exp;
                        if (i == p)      issue(k ? C_PRE : C_BST, 0, 1'b0, 1'b0, 1'b1);
                        else if (i < p)  issue((i == 0) ? C_WR : C_NOP, 0, 1'b0, m[i], 1'b1);
                        else             issue(C_NOP, 0, 1'b0, 1'b0, 1'b1);
                        exp = (i < p && !m[i]) ? 1 : 0;
                        if (p == 4)      check("R9 beat", int'(wbeat_valid), exp);
                        else if (k == 1) check("R11 beat", int'(wbeat_valid), exp);
                        else             check("R10 beat", int'(wbeat_valid), exp);
                        check("R12 full page beat", int'(fp_wbeat), exp);
                    end
                    issue(C_NOP, 0, 1'b0, 1'b0, 1'b1);
                    check("R9 burst over", int'(wbeat_valid), 0);
                    check("R12 full page continues", int'(fp_wbeat), (p == 4) ? 1 : 0);
                    if (p < 4 && k == 1) check("R11 bank closed", int'(bank_open[0]), 0);
                end
            end
        end

        // R12: long full-page burst
        do_reset();
        issue(C_ACT, 0, 1'b0, 1'b0, 1'b1);
        issue(C_WR, 0, 1'b0, 1'b0, 1'b1);
        check("R12 beat 0", int'(fp_wbeat), 1);
        for (int n = 0; n < 10; n++) begin
            issue(C_NOP, 0, 1'b0, 1'b0, 1'b1);
            check("R12 full page beat", int'(fp_wbeat), 1);
            check("R9 fixed length", int'(wbeat_valid), (n < 3) ? 1 : 0);
        end
        issue(C_BST, 0, 1'b0, 1'b0, 1'b1);
        check("R12 stop drops", int'(fp_wbeat), 0);
        issue(C_NOP, 0, 1'b0, 1'b0, 1'b1);
        check("R12 stopped", int'(fp_wbeat), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule